// File: doc/BRIEF.md
# Range clamp and depth expander

This stage sits in a display output pipe and works on one pixel per clock. Each pixel arrives as three 12-bit components in a common container, with a valid strobe and per-pixel configuration. The stage can first widen a component that was produced at 8 or 10 bits to the full 12 bits. It then limits each component to the video limited range of a chosen bit depth. Finally it emits the pixel either as three parallel components or as 4:2:2, where the two chroma components take turns on a single channel.

The configuration travels with the data. A change of mode therefore takes effect exactly on the pixel that carries it, and no pipeline flush is needed. Results appear two clock cycles after the pixel is accepted. They carry the encoding code of that pixel as a tag, and in 4:2:2 a select bit that tells Cb and Cr apart.

Top module: `range_depth_stage`

## Requirements
- R1: While reset is high, and in the first cycle after it, out_valid is 0 and every output data field is 0.
- R2: A pixel presented with in_valid high at a rising edge appears on the outputs with out_valid high after exactly two rising edges. out_valid is never high without such a pixel.
- R3: With cfg_exp_en=1 and cfg_exp_mode=1, each component is treated as an 8-bit value in bits [11:4]. Its four low bits are replaced by copies of bits [11:8], so 0xFF0 becomes 0xFFF.
- R4: With cfg_exp_en=1 and cfg_exp_mode=0, each component is treated as a 10-bit value in bits [11:2]. Its two low bits are replaced by copies of bits [11:10].
- R5: With cfg_exp_en=0, components pass the widening step unchanged, whatever cfg_exp_mode is.
- R6: With cfg_clamp_en=1, the clamp depth is 8, 10 or 12 bits for cfg_clamp_fmt = 1, 2 or 3. The top d bits of the component are compared with the bounds 16..235 scaled by 4 per extra two bits. A value below the lower bound is replaced by that bound placed in the top d bits. A value above the upper bound is replaced likewise by the upper bound. Any other value passes untouched.
- R7: When cfg_ycbcr=1, components 1 and 2 use an upper bound of 240 (scaled as in R6), while component 0 keeps the 235 bound. When cfg_ycbcr=0, all three components use 235.
- R8: No clamping occurs when cfg_clamp_en=0, or when cfg_clamp_fmt is 0 (full range), 7 (programmable limits, not built) or 4 to 6.
- R9: Widening is applied before clamping. The clamp therefore sees the widened value.
- R10: With cfg_enc=1 (4:2:2), out_c0 carries component 0 of each pixel and out_c2 is 0. On out_c1, an even pixel outputs its own component 1 (Cb) with out_csel=0. The following odd pixel outputs the even pixel's component 2 (Cr) with out_csel=1. The odd pixel's chroma is dropped. Only valid pixels advance the even/odd phase.
- R11: Any valid pixel with cfg_enc other than 1 returns the phase to even, so the next 4:2:2 pixel is treated as even.
- R12: With cfg_enc of 0, 2 or 3, all three components pass in parallel and out_csel=0. Every output pixel carries its own cfg_enc on out_enc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel and configuration are present |
| in_c0 | input | 12 | Component 0 (G or Y) |
| in_c1 | input | 12 | Component 1 (B or Cb) |
| in_c2 | input | 12 | Component 2 (R or Cr) |
| cfg_exp_en | input | 1 | Widening enable |
| cfg_exp_mode | input | 1 | 1: widen from 8 bits, 0: widen from 10 bits |
| cfg_clamp_en | input | 1 | Clamp enable |
| cfg_clamp_fmt | input | 3 | Clamp depth code (1/2/3 = 8/10/12 bits) |
| cfg_ycbcr | input | 1 | Components 1 and 2 are chroma |
| cfg_enc | input | 2 | 0: 4:4:4, 1: 4:2:2, 2: 4:2:0, 3: reserved |
| out_valid | output | 1 | Output pixel present |
| out_c0 | output | 12 | Component 0 result |
| out_c1 | output | 12 | Component 1 result, or alternating chroma in 4:2:2 |
| out_c2 | output | 12 | Component 2 result, 0 in 4:2:2 |
| out_enc | output | 2 | Encoding tag of the output pixel |
| out_csel | output | 1 | In 4:2:2, 0 = Cb and 1 = Cr on out_c1 |

## Verification
The bench aims at the edges of each clamp window. It uses values one step inside and one step outside the bounds at each depth, and a value that passes at 8-bit depth but is cut at 10 and 12 bits. A comparator that ignored the low bits of the selected depth, or that applied the chroma bound to component 0, would give a wrong result on exactly one of those vectors.

Widening is checked with full-scale, mid-scale and low codes. Copying the wrong bits would break full scale to full scale, and a disabled enable that still widened would alter the result.

In 4:2:2 the bench sends pixels with idle gaps between them and then leaves and re-enters the mode. A design that stepped the phase on idle cycles would swap Cb and Cr. A design that kept a stale phase would start on Cr.

// File: rtl/rds_pkg.sv
package rds_pkg;

    localparam int COMP_W     = 12;
    localparam int NUM_CH     = 3;
    localparam int FMT_W      = 3;
    localparam int ENC_W      = 2;
    localparam int NARROW_A   = 8;
    localparam int NARROW_B   = 10;
    localparam int BASE_DEPTH = 8;
    localparam int LIM_LO     = 16;
    localparam int LIM_HI_Y   = 235;
    localparam int LIM_HI_C   = 240;
    localparam int BASE_SHIFT = COMP_W - BASE_DEPTH;

    localparam logic [FMT_W-1:0] FMT_DEPTH8  = 3'd1;
    localparam logic [FMT_W-1:0] FMT_DEPTH10 = 3'd2;
    localparam logic [FMT_W-1:0] FMT_DEPTH12 = 3'd3;

    typedef logic [COMP_W-1:0] comp_t;
    typedef comp_t [NUM_CH-1:0] pix_t;

    typedef enum logic [ENC_W-1:0] {
        ENC_444 = 2'd0,
        ENC_422 = 2'd1,
        ENC_420 = 2'd2,
        ENC_RSV = 2'd3
    } enc_e;

    typedef struct packed {
        logic       valid;
        pix_t       px;
        logic       clamp_on;
        logic [1:0] depth;
        logic       ycbcr;
        enc_e       enc;
    } stage_t;

    // Keep the top `src` bits and fill the rest by repeating the top bits.
    function automatic comp_t widen(input comp_t v, input int src);
        comp_t r;
        r = v;
        for (int i = 0; i < COMP_W - src; i++) begin
            r[COMP_W-src-1-i] = v[COMP_W-1-i];
        end
        return r;
    endfunction

    function automatic logic clamp_active(input logic en, input logic [FMT_W-1:0] fmt);
        return en && (fmt == FMT_DEPTH8 || fmt == FMT_DEPTH10 || fmt == FMT_DEPTH12);
    endfunction

    // Depth index 0/1/2 stands for 8/10/12 bits.
    function automatic logic [1:0] depth_index(input logic [FMT_W-1:0] fmt);
        logic [1:0] r;
        r = fmt[1:0] - 2'd1;
        return r;
    endfunction

    function automatic comp_t limit_comp(input comp_t v, input logic [1:0] didx,
                                         input logic chroma);
        int unsigned scale;
        int unsigned sh;
        comp_t top;
        comp_t lo;
        comp_t hi;
        comp_t r;
        scale = 2 * int'(didx);
        sh    = BASE_SHIFT - scale;
        top   = v >> sh;
        lo    = comp_t'(LIM_LO) << scale;
        hi    = (chroma ? comp_t'(LIM_HI_C) : comp_t'(LIM_HI_Y)) << scale;
        if (top < lo)      r = lo << sh;
        else if (top > hi) r = hi << sh;
        else               r = v;
        return r;
    endfunction

endpackage

// File: rtl/rds_widen_stage.sv
module rds_widen_stage
    import rds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  pix_t             px_i,
    input  logic             exp_en,
    input  logic             exp_mode,
    input  logic             clamp_en,
    input  logic [FMT_W-1:0] clamp_fmt,
    input  logic             ycbcr,
    input  enc_e             enc,
    output stage_t           s1_q
);

    pix_t px_w;

    always_comb begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (!exp_en)       px_w[ch] = px_i[ch];
            else if (exp_mode) px_w[ch] = widen(px_i[ch], NARROW_A);
            else               px_w[ch] = widen(px_i[ch], NARROW_B);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.valid <= in_valid;
            if (in_valid) begin
                s1_q.px       <= px_w;
                s1_q.clamp_on <= clamp_active(clamp_en, clamp_fmt);
                s1_q.depth    <= depth_index(clamp_fmt);
                s1_q.ycbcr    <= ycbcr;
                s1_q.enc      <= enc;
            end
        end
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_q.valid);

    p_fullscale8_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid && exp_en && exp_mode && (&px_i[0][COMP_W-1 -: NARROW_A])
        |=> (&s1_q.px[0]));

    p_fullscale10_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid && exp_en && !exp_mode && (&px_i[0][COMP_W-1 -: NARROW_B])
        |=> (&s1_q.px[0]));

    p_no_widen_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid && !exp_en |=> s1_q.px == $past(px_i));

endmodule

// File: rtl/rds_limiter.sv
module rds_limiter
    import rds_pkg::*;
#(
    parameter bit CHROMA_CAPABLE = 1'b0
) (
    input  comp_t      comp_i,
    input  logic       clamp_on,
    input  logic [1:0] depth,
    input  logic       ycbcr,
    output comp_t      comp_o
);

    logic use_chroma;

    assign use_chroma = CHROMA_CAPABLE && ycbcr;

    always_comb begin
        if (clamp_on) comp_o = limit_comp(comp_i, depth, use_chroma);
        else          comp_o = comp_i;
    end

endmodule

// File: rtl/rds_packer.sv
module rds_packer
    import rds_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  s1_valid,
    input  enc_e  s1_enc,
    input  pix_t  px_i,
    output logic  out_valid,
    output comp_t out_c0,
    output comp_t out_c1,
    output comp_t out_c2,
    output enc_e  out_enc,
    output logic  out_csel
);

    logic  odd_q;
    comp_t cr_hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_c0    <= '0;
            out_c1    <= '0;
            out_c2    <= '0;
            out_enc   <= ENC_444;
            out_csel  <= 1'b0;
            odd_q     <= 1'b0;
            cr_hold_q <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_c0  <= px_i[0];
                out_enc <= s1_enc;
                if (s1_enc == ENC_422) begin
                    out_c2 <= '0;
                    if (!odd_q) begin
                        out_c1    <= px_i[1];
                        cr_hold_q <= px_i[2];
                        out_csel  <= 1'b0;
                        odd_q     <= 1'b1;
                    end else begin
                        out_c1   <= cr_hold_q;
                        out_csel <= 1'b1;
                        odd_q    <= 1'b0;
                    end
                end else begin
                    out_c1   <= px_i[1];
                    out_c2   <= px_i[2];
                    out_csel <= 1'b0;
                    odd_q    <= 1'b0;
                end
            end
        end
    end

    p_forward_r2: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !out_valid);

    p_422_c2_zero_r10: assert property (@(posedge clk) disable iff (rst)
        s1_valid && s1_enc == ENC_422 |=> out_c2 == '0);

    p_422_odd_cr_r10: assert property (@(posedge clk) disable iff (rst)
        s1_valid && s1_enc == ENC_422 && odd_q |=> out_csel);

    p_phase_restart_r11: assert property (@(posedge clk) disable iff (rst)
        s1_valid && s1_enc != ENC_422 |=> !odd_q);

    p_parallel_sel_r12: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_enc != ENC_422 |-> !out_csel);

endmodule

// File: rtl/range_depth_stage.sv
module range_depth_stage
    import rds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [COMP_W-1:0] in_c0,
    input  logic [COMP_W-1:0] in_c1,
    input  logic [COMP_W-1:0] in_c2,
    input  logic              cfg_exp_en,
    input  logic              cfg_exp_mode,
    input  logic              cfg_clamp_en,
    input  logic [FMT_W-1:0]  cfg_clamp_fmt,
    input  logic              cfg_ycbcr,
    input  logic [ENC_W-1:0]  cfg_enc,
    output logic              out_valid,
    output logic [COMP_W-1:0] out_c0,
    output logic [COMP_W-1:0] out_c1,
    output logic [COMP_W-1:0] out_c2,
    output logic [ENC_W-1:0]  out_enc,
    output logic              out_csel
);

    localparam comp_t FLOOR  = comp_t'(LIM_LO << BASE_SHIFT);
    localparam comp_t CEIL_Y = comp_t'((LIM_HI_Y + 1) << BASE_SHIFT);
    localparam comp_t CEIL_C = comp_t'((LIM_HI_C + 1) << BASE_SHIFT);

    pix_t   px_in;
    pix_t   lim_px;
    stage_t s1_q;
    enc_e   enc_out;

    assign px_in = {in_c2, in_c1, in_c0};

    rds_widen_stage u_widen (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .px_i      (px_in),
        .exp_en    (cfg_exp_en),
        .exp_mode  (cfg_exp_mode),
        .clamp_en  (cfg_clamp_en),
        .clamp_fmt (cfg_clamp_fmt),
        .ycbcr     (cfg_ycbcr),
        .enc       (enc_e'(cfg_enc)),
        .s1_q      (s1_q)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lim
        rds_limiter #(.CHROMA_CAPABLE(ch != 0)) u_lim (
            .comp_i   (s1_q.px[ch]),
            .clamp_on (s1_q.clamp_on),
            .depth    (s1_q.depth),
            .ycbcr    (s1_q.ycbcr),
            .comp_o   (lim_px[ch])
        );
    end

    rds_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_q.valid),
        .s1_enc    (s1_q.enc),
        .px_i      (lim_px),
        .out_valid (out_valid),
        .out_c0    (out_c0),
        .out_c1    (out_c1),
        .out_c2    (out_c2),
        .out_enc   (enc_out),
        .out_csel  (out_csel)
    );

    assign out_enc = enc_out;

    p_luma_window_r6: assert property (@(posedge clk) disable iff (rst)
        s1_q.valid && s1_q.clamp_on |-> lim_px[0] >= FLOOR && lim_px[0] < CEIL_Y);

    p_chroma_window_r7: assert property (@(posedge clk) disable iff (rst)
        s1_q.valid && s1_q.clamp_on |-> lim_px[1] >= FLOOR && lim_px[1] < CEIL_C
                                     && lim_px[2] >= FLOOR && lim_px[2] < CEIL_C);

    p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
        s1_q.valid && !s1_q.clamp_on |-> lim_px == s1_q.px);

endmodule

// File: tb/range_depth_stage_bench.sv
`timescale 1ns/1ps
module range_depth_stage_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
    logic        cfg_exp_en = 1'b0, cfg_exp_mode = 1'b0, cfg_clamp_en = 1'b0, cfg_ycbcr = 1'b0;
    logic [2:0]  cfg_clamp_fmt = '0;
    logic [1:0]  cfg_enc = '0;
    logic        out_valid;
    logic [11:0] out_c0, out_c1, out_c2;
    logic [1:0]  out_enc;
    logic        out_csel;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    range_depth_stage u_range_depth_stage (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
        .cfg_exp_en(cfg_exp_en), .cfg_exp_mode(cfg_exp_mode),
        .cfg_clamp_en(cfg_clamp_en), .cfg_clamp_fmt(cfg_clamp_fmt),
        .cfg_ycbcr(cfg_ycbcr), .cfg_enc(cfg_enc),
        .out_valid(out_valid), .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2),
        .out_enc(out_enc), .out_csel(out_csel)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        xe;
        logic        xm;
        logic        ce;
        logic [2:0]  fmt;
        logic        yc;
        logic [11:0] i0, i1, i2;
        logic [11:0] e0, e1, e2;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        // R5 all stages idle
        '{4'd5, 1'b0,1'b0,1'b0,3'd0,1'b0, 12'h123,12'hABC,12'hFFF, 12'h123,12'hABC,12'hFFF},
        // R3 widen from 8 bits
        '{4'd3, 1'b1,1'b1,1'b0,3'd0,1'b0, 12'hFF0,12'h800,12'h010, 12'hFFF,12'h808,12'h010},
        // R4 widen from 10 bits
        '{4'd4, 1'b1,1'b0,1'b0,3'd0,1'b0, 12'hFFC,12'h804,12'h400, 12'hFFF,12'h806,12'h401},
        // R5 mode set but enable low
        '{4'd5, 1'b0,1'b1,1'b0,3'd0,1'b0, 12'hFF0,12'h001,12'h555, 12'hFF0,12'h001,12'h555},
        // R6 8-bit clamp, RGB
        '{4'd6, 1'b0,1'b0,1'b1,3'd1,1'b0, 12'h000,12'hFFF,12'hEBA, 12'h100,12'hEB0,12'hEBA},
        // R6 10-bit clamp, RGB
        '{4'd6, 1'b0,1'b0,1'b1,3'd2,1'b0, 12'hEBA,12'h0FF,12'h100, 12'hEB0,12'h100,12'h100},
        // R7 12-bit clamp, YCbCr
        '{4'd7, 1'b0,1'b0,1'b1,3'd3,1'b1, 12'hEB1,12'hF00,12'hF01, 12'hEB0,12'hF00,12'hF00},
        // R7 8-bit clamp, YCbCr
        '{4'd7, 1'b0,1'b0,1'b1,3'd1,1'b1, 12'hEC0,12'hF0F,12'hF10, 12'hEB0,12'hF0F,12'hF00},
        // R8 full-range code 0
        '{4'd8, 1'b0,1'b0,1'b1,3'd0,1'b0, 12'h000,12'hFFF,12'h00F, 12'h000,12'hFFF,12'h00F},
        // R8 programmable code 7
        '{4'd8, 1'b0,1'b0,1'b1,3'd7,1'b0, 12'h005,12'hFFE,12'h0A0, 12'h005,12'hFFE,12'h0A0},
        // R8 clamp enable low
        '{4'd8, 1'b0,1'b0,1'b0,3'd1,1'b0, 12'h000,12'hFFF,12'h050, 12'h000,12'hFFF,12'h050},
        // R9 widen then 12-bit clamp
        '{4'd9, 1'b1,1'b1,1'b1,3'd3,1'b0, 12'hFF0,12'h000,12'h800, 12'hEB0,12'h100,12'h808}
    };

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic xe, input logic xm, input logic ce, input logic [2:0] fmt,
                         input logic yc, input logic [1:0] enc,
                         input logic [11:0] a, input logic [11:0] b, input logic [11:0] c);
        @(negedge clk);
        cfg_exp_en = xe; cfg_exp_mode = xm; cfg_clamp_en = ce; cfg_clamp_fmt = fmt;
        cfg_ycbcr = yc; cfg_enc = enc;
        in_c0 = a; in_c1 = b; in_c2 = c;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_pix(input string tag, input logic [1:0] enc, input logic sel,
                              input logic [11:0] a, input logic [11:0] b, input logic [11:0] c);
        chk({tag, " valid"}, {11'd0, out_valid}, 12'd1);
        chk({tag, " c0"}, out_c0, a);
        chk({tag, " c1"}, out_c1, b);
        chk({tag, " c2"}, out_c2, c);
        chk({tag, " enc"}, {10'd0, out_enc}, {10'd0, enc});
        chk({tag, " csel"}, {11'd0, out_csel}, {11'd0, sel});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs held at zero under reset
        chk("R1 valid in reset", {11'd0, out_valid}, 12'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid", {11'd0, out_valid}, 12'd0);
        chk("R1 c0", out_c0, 12'd0);
        chk("R1 c1", out_c1, 12'd0);
        chk("R1 c2", out_c2, 12'd0);
        chk("R1 csel", {11'd0, out_csel}, 12'd0);

        for (int k = 0; k < NV; k++) begin
            drive(TBL[k].xe, TBL[k].xm, TBL[k].ce, TBL[k].fmt, TBL[k].yc, 2'd0,
                  TBL[k].i0, TBL[k].i1, TBL[k].i2);
            expect_pix($sformatf("R%0d vec%0d", TBL[k].req, k), 2'd0, 1'b0,
                       TBL[k].e0, TBL[k].e1, TBL[k].e2);
        end

        // R2 two-edge latency, no output without input
        @(negedge clk);
        cfg_exp_en = 0; cfg_clamp_en = 0; cfg_enc = 0;
        in_c0 = 12'h321; in_c1 = 12'h654; in_c2 = 12'h987; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 not yet valid", {11'd0, out_valid}, 12'd0);
        @(negedge clk);
        chk("R2 valid after two edges", {11'd0, out_valid}, 12'd1);
        chk("R2 data", out_c0, 12'h321);
        @(negedge clk);
        chk("R2 drops when idle", {11'd0, out_valid}, 12'd0);

        // R10 4:2:2 with idle gaps between pixels
        drive(0,0,0,3'd0,1,2'd1, 12'h111,12'h222,12'h333);
        expect_pix("R10 p0", 2'd1, 1'b0, 12'h111, 12'h222, 12'h000);
        drive(0,0,0,3'd0,1,2'd1, 12'h444,12'h555,12'h666);
        expect_pix("R10 p1", 2'd1, 1'b1, 12'h444, 12'h333, 12'h000);
        drive(0,0,0,3'd0,1,2'd1, 12'h777,12'h888,12'h999);
        expect_pix("R10 p2", 2'd1, 1'b0, 12'h777, 12'h888, 12'h000);
        drive(0,0,0,3'd0,1,2'd1, 12'hAAA,12'hBBB,12'hCCC);
        expect_pix("R10 p3", 2'd1, 1'b1, 12'hAAA, 12'h999, 12'h000);

        // R11 leave 4:2:2 on an odd phase, then come back
        drive(0,0,0,3'd0,1,2'd1, 12'h101,12'h202,12'h303);
        expect_pix("R11 even", 2'd1, 1'b0, 12'h101, 12'h202, 12'h000);
        drive(0,0,0,3'd0,1,2'd0, 12'h404,12'h505,12'h606);
        expect_pix("R11 parallel", 2'd0, 1'b0, 12'h404, 12'h505, 12'h606);
        drive(0,0,0,3'd0,1,2'd1, 12'h707,12'h808,12'h909);
        expect_pix("R11 restart even", 2'd1, 1'b0, 12'h707, 12'h808, 12'h000);

        // R12 4:2:0 and reserved codes pass in parallel with their tag
        drive(0,0,0,3'd0,1,2'd2, 12'h0AB,12'h0CD,12'h0EF);
        expect_pix("R12 enc2", 2'd2, 1'b0, 12'h0AB, 12'h0CD, 12'h0EF);
        drive(0,0,0,3'd0,0,2'd3, 12'hFED,12'hCBA,12'h987);
        expect_pix("R12 enc3", 2'd3, 1'b0, 12'hFED, 12'hCBA, 12'h987);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule